// File: doc/BRIEF.md
# Microsecond-Timed Hot-Plug Pulse Generator

This block drives a hot-plug-detect line toward an upstream source. It normally holds the line high. When software asks for an interrupt pulse, it pulls the line low for a programmed number of microseconds and then releases it. A programmable divider turns the system clock into a one-microsecond tick that times the pulse. The divider restarts when a pulse begins, so the pulse width is exact: the length times the tick period, in clocks.

The same configuration word that holds the divide value also holds a width threshold for a glitch filter. The filter cleans up a single-wire input coming from the link side. A level change on that wire reaches the filtered output only after the wire has held the new level for the programmed number of clocks.

Software reaches the block through a write-only strobe with a one-bit register select. Select 0 is the timing word. Select 1 is the pulse command.

Top module: `hpd_pulse_gen`

## Requirements
- R1: After reset, `hpd_out` is 1, `busy` is 0 and `sig_filt` is 0.
- R2: A started pulse holds `hpd_out` at 0 for exactly LEN × (DIV + 1) clock cycles. DIV is bits 7:0 of the timing word (select 0). LEN is bits 31:16 of the pulse command (select 1). Afterwards `hpd_out` returns to 1.
- R3: A divide value of 0 acts as 1, so the tick period is 2 clocks.
- R4: A write to the pulse command starts a pulse only when bit 0 is 1. A command with bit 0 clear leaves `hpd_out` at 1 and `busy` at 0.
- R5: `busy` is 1 in exactly the cycles in which `hpd_out` is held low by a pulse.
- R6: An assert command that arrives while a pulse is in progress is ignored. The running pulse keeps its original length.
- R7: A command with bit 0 set and a length of 0 produces no pulse. `hpd_out` stays 1 and `busy` stays 0.
- R8: The filter threshold N is bits 15:8 of the timing word. A level change on `sig_in` appears on `sig_filt` N+1 clock edges after it is first sampled, counting the sampling edge. A level held for fewer than N clocks never appears on `sig_filt`.
- R9: A filter threshold of 0 acts as 1, so a change appears on `sig_filt` 2 clock edges after `sig_in` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_sel | input | 1 | 0 selects the timing word, 1 selects the pulse command |
| cfg_wdata | input | 32 | Write data |
| sig_in | input | 1 | Raw single-wire input to be filtered |
| sig_filt | output | 1 | Filtered copy of `sig_in` |
| hpd_out | output | 1 | Hot-plug-detect line, low during a pulse |
| busy | output | 1 | High for the whole of a pulse |

## Verification
The assertions assume the following about the inputs:
- `cfg_wr` is a single-cycle strobe.
- `sig_in` is already synchronous to `clk`.
- The timing word does not change while a pulse is running. If it did, the tick period, and with it the pulse width, would shift in the middle of a pulse.

The bench drives every input at the falling clock edge. It rewrites the timing word only while the block is idle. The only write it makes during a pulse is the deliberate re-trigger, and that write targets the pulse command, never the divider.

// File: rtl/hpg_pkg.sv
// Package: field positions and widths shared by the hot-plug pulse blocks.
// Assumes a 32-bit configuration write bus.
package hpg_pkg;
    localparam int DATA_W   = 32;
    localparam int DIV_W    = 8;
    localparam int FILT_W   = 8;
    localparam int LEN_W    = 16;
    localparam int DIV_LSB  = 0;
    localparam int FILT_LSB = 8;
    localparam int LEN_LSB  = 16;
    localparam int GO_BIT   = 0;

    typedef enum logic {
        SEL_TIMING = 1'b0,
        SEL_PULSE  = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/hpg_tick_div.sv
// Module: microsecond tick divider.
// Counts clocks from 0 up to the divide value and emits a one-cycle tick
// when the count reaches it. A divide value of 0 is treated as 1.
// `restart` zeroes the count so that a new pulse starts on a full period.
module hpg_tick_div #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] div_val,
    input  logic         restart,
    output logic         tick
);
    logic [W-1:0] cnt;
    logic [W-1:0] lim;

    // Effective limit: a divide value of 0 behaves as 1.
    always_comb lim = (div_val == '0) ? W'(1) : div_val;

    // Tick when the count has reached the limit; >= survives a lowered limit.
    always_comb tick = (cnt >= lim);

    // Count register: wraps on tick, clears on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // R3: with a limit of at least 1, two ticks are never back to back.
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/hpg_pulse_ctl.sv
// Module: pulse sequencer for the hot-plug line.
// Accepts an assert request only when idle and when the length is non-zero.
// While busy it drives HPD low and counts ticks. When the count reaches the
// latched length it releases HPD. Assumes `tick` is a single-cycle strobe.
module hpg_pulse_ctl #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [LW-1:0] len,
    input  logic          tick,
    output logic          start,
    output logic          busy,
    output logic          hpd
);
    logic [LW-1:0] len_q;
    logic [LW-1:0] us_cnt;
    logic [LW-1:0] us_nxt;

    // Start only when idle with a non-zero length; anything else is dropped.
    always_comb start = go && !busy && (len != '0);
    always_comb us_nxt = us_cnt + 1'b1;

    // Pulse state: busy flag, HPD level, latched length and tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            hpd    <= 1'b1;
            len_q  <= '0;
            us_cnt <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            hpd    <= 1'b0;
            len_q  <= len;
            us_cnt <= '0;
        end else if (busy && tick) begin
            us_cnt <= us_nxt;
            if (us_nxt == len_q) begin
                busy <= 1'b0;
                hpd  <= 1'b1;
            end
        end
    end

    // R5: busy and the low level of HPD coincide.
    a_r5_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        busy != hpd);
    // R6: while a pulse runs, its count never jumps back.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (us_cnt >= $past(us_cnt)));
    // R7: a zero-length request from idle leaves the line released.
    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && len == '0) |=> (!busy && hpd));
    // R2: the count stays below the latched length during a pulse.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (us_cnt < len_q));
endmodule

// File: rtl/hpg_glitch_filt.sv
// Module: width filter for a single-wire input.
// Samples the input once. The output takes a new level only after the
// sampled input has differed from it for `thresh` consecutive clocks.
// A threshold of 0 is treated as 1. Assumes the input is synchronous to clk.
module hpg_glitch_filt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] thresh,
    input  logic         din,
    output logic         dout
);
    logic         s_q;
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_nxt;
    logic [W-1:0] need;

    // Effective threshold: 0 behaves as 1.
    always_comb need = (thresh == '0) ? W'(1) : thresh;
    always_comb cnt_nxt = cnt + 1'b1;

    // Input sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= din;
    end

    // Stability counter and output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dout <= 1'b0;
        end else if (s_q != dout) begin
            if (cnt_nxt >= need) begin
                dout <= s_q;
                cnt  <= '0;
            end else begin
                cnt  <= cnt_nxt;
            end
        end else begin
            cnt <= '0;
        end
    end

    // R8: the output only ever moves to the level the sampled input held.
    a_r8_follow_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> (dout == $past(s_q)));
endmodule

// File: rtl/hpd_pulse_gen.sv
// Module: top of the hot-plug pulse generator.
// Decodes the two write-only configuration words and wires the microsecond
// divider, the pulse sequencer and the input glitch filter together.
// Assumes cfg_wr is a single-cycle strobe.
module hpd_pulse_gen
    import hpg_pkg::*;
#(
    parameter logic [DIV_W-1:0]  DIV_RESET  = 8'd49,
    parameter logic [FILT_W-1:0] FILT_RESET = 8'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              sig_in,
    output logic              sig_filt,
    output logic              hpd_out,
    output logic              busy
);
    logic [DIV_W-1:0]  div_q;
    logic [FILT_W-1:0] filt_q;
    logic              go;
    logic              start;
    logic              tick;
    logic [LEN_W-1:0]  len;

    // Timing word register: divide value and filter threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= DIV_RESET;
            filt_q <= FILT_RESET;
        end else if (cfg_wr && cfg_sel == SEL_TIMING) begin
            div_q  <= cfg_wdata[DIV_LSB +: DIV_W];
            filt_q <= cfg_wdata[FILT_LSB +: FILT_W];
        end
    end

    // Pulse command decode: assert bit and microsecond length.
    always_comb begin
        go  = cfg_wr && (cfg_sel == SEL_PULSE) && cfg_wdata[GO_BIT];
        len = cfg_wdata[LEN_LSB +: LEN_W];
    end

    hpg_tick_div #(.W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_q),
        .restart (start),
        .tick    (tick)
    );

    hpg_pulse_ctl #(.LW(LEN_W)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .len   (len),
        .tick  (tick),
        .start (start),
        .busy  (busy),
        .hpd   (hpd_out)
    );

    hpg_glitch_filt #(.W(FILT_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .thresh (filt_q),
        .din    (sig_in),
        .dout   (sig_filt)
    );

    // R4: a command with the assert bit clear never starts a pulse.
    a_r4_need_go: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel && !cfg_wdata[GO_BIT] && !busy) |=> !busy);
endmodule

// File: tb/tb_hpd_pulse_gen.sv
module tb_hpd_pulse_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        sig_in = 1'b0;
    logic        sig_filt, hpd_out, busy;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    hpd_pulse_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .sig_in(sig_in), .sig_filt(sig_filt),
        .hpd_out(hpd_out), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One write, issued at a falling edge, accepted at the next rising edge.
    task automatic wr(input bit sel, input logic [31:0] data);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    function automatic logic [31:0] timing(input int filt, input int div);
        return (32'(filt) << 8) | 32'(div);
    endfunction

    // Counts low cycles of HPD and checks that busy tracks it.
    task automatic count_low(output int n, output int busy_bad);
        n = 0; busy_bad = 0;
        while (hpd_out == 1'b0 && n < 5000) begin
            if (busy !== 1'b1) busy_bad++;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check(hpd_out == 1'b1, "R1 hpd", hpd_out, 1);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(sig_filt == 1'b0, "R1 filt", sig_filt, 0);
    endtask

    task automatic t_pulse(input int div, input int len, input int exp, input string req);
        int n, bb;
        wr(1'b0, timing(4, div));
        wr(1'b1, (32'(len) << 16) | 32'h1);
        count_low(n, bb);
        check(n == exp, req, n, exp);
        check(bb == 0, "R5 busy during pulse", bb, 0);
        check(busy == 1'b0 && hpd_out == 1'b1, "R5 idle after pulse", busy, 0);
    endtask

    task automatic t_no_go;
        int low = 0;
        wr(1'b0, timing(4, 3));
        wr(1'b1, (32'd5 << 16));
        for (int i = 0; i < 30; i++) begin
            if (hpd_out !== 1'b1 || busy !== 1'b0) low++;
            @(negedge clk);
        end
        check(low == 0, "R4 no pulse without assert bit", low, 0);
    endtask

    task automatic t_zero_len;
        int low = 0;
        wr(1'b1, 32'h1);
        for (int i = 0; i < 30; i++) begin
            if (hpd_out !== 1'b1 || busy !== 1'b0) low++;
            @(negedge clk);
        end
        check(low == 0, "R7 zero length", low, 0);
    endtask

    task automatic t_retrigger;
        int n = 0;
        wr(1'b0, timing(4, 3));
        wr(1'b1, (32'd4 << 16) | 32'h1);
        while (hpd_out == 1'b0 && n < 5000) begin
            if (n == 5) begin
                cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = (32'd10 << 16) | 32'h1;
            end else begin
                cfg_wr = 1'b0; cfg_wdata = '0;
            end
            n++;
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        check(n == 16, "R6 retrigger ignored", n, 16);
    endtask

    // Change sig_in to lvl; expect sig_filt to move after exactly thr+1 edges.
    task automatic filt_edge(input bit lvl, input int thr, input string req);
        sig_in = lvl;
        for (int i = 0; i < thr; i++) @(negedge clk);
        check(sig_filt == !lvl, {req, " too early"}, sig_filt, !lvl);
        @(negedge clk);
        check(sig_filt == lvl, {req, " on time"}, sig_filt, lvl);
    endtask

    task automatic t_filter;
        int moved = 0;
        wr(1'b0, timing(4, 3));
        sig_in = 1'b1;
        repeat (3) @(negedge clk);
        sig_in = 1'b0;
        for (int i = 0; i < 10; i++) begin
            if (sig_filt !== 1'b0) moved++;
            @(negedge clk);
        end
        check(moved == 0, "R8 short glitch rejected", moved, 0);
        filt_edge(1'b1, 4, "R8 rise");
        filt_edge(1'b0, 4, "R8 fall");
    endtask

    task automatic t_filter_zero;
        wr(1'b0, timing(0, 3));
        filt_edge(1'b1, 1, "R9 threshold 0 rise");
        filt_edge(1'b0, 1, "R9 threshold 0 fall");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pulse(3, 5, 20, "R2 div 3 len 5");
        t_pulse(1, 1, 2, "R2 div 1 len 1");
        t_pulse(0, 3, 6, "R3 divide value 0");
        t_pulse(7, 2, 16, "R2 div 7 len 2");
        t_no_go();
        t_zero_len();
        t_retrigger();
        t_filter();
        t_filter_zero();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule